// File: doc/BRIEF.md
# Scaled Float-to-Fixed Saturating Converter

This block turns four single-precision floating-point values, packed side by side in a 128-bit operand, into four signed 32-bit integers. Before the conversion, each value is scaled by a power of two chosen by a 5-bit unsigned scale input. The scale is applied by adding it to the exponent, so the block needs no multiplier. The scaled value is truncated toward zero. If it does not fit in a signed 32-bit integer, it is clamped to the nearest limit, and that lane is flagged as saturated.

Every result leaves with a per-operation saturation flag. The block also keeps a sticky saturation status bit. Any saturating operation sets that bit, and only the dedicated clear input resets it. A mode input asks for denormal inputs to be flushed to zero. A denormal scaled by at most 2^31 is still below one in magnitude, so the result is 0 in both modes.

The block has a single register stage with valid/ready handshakes on both sides.
- An operand is accepted in a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds its value, and no new operand is taken.

Top module: `f2fix_scaled`

## Requirements
- R1: Lane i of `in_vec` (bits 32i+31 down to 32i: sign in the top bit, 8-bit biased exponent below it, 23-bit fraction in the low bits) produces its result in bits 32i+31 down to 32i of `out_vec`, independent of the other lanes.
- R2: For a finite input x and scale s (0 to 31), the lane result is x·2^s truncated toward zero, in two's complement.
- R3: A scaled value of 2^31 or more gives 0x7FFFFFFF, and one below -2^31 gives 0x80000000. Both raise saturation. A scaled value of exactly -2^31 gives 0x80000000 without saturation. A huge exponent combined with a large scale still clamps and never wraps.
- R4: A NaN lane (exponent all ones, fraction non-zero) gives 0 and raises saturation. +infinity gives 0x7FFFFFFF and -infinity gives 0x80000000, and both raise saturation.
- R5: Zero, negative zero and denormal inputs (exponent 0) give 0 without saturation, whether `flush_dn` is high or low.
- R6: `out_sat` is the OR of the saturation of the four lanes of the operation currently shown on `out_vec`.
- R7: The following clock edge sets `sat_sticky` when a saturating operation is accepted, and `sat_sticky` holds at 1 otherwise. `sat_clear` resets it unless a saturating operation is accepted in the same cycle, in which case the bit ends up set.
- R8: Results appear with `out_valid` in the cycle after acceptance. `in_ready` equals `!out_valid || out_ready`, and `out_vec`/`out_sat` stay stable while `out_valid && !out_ready`.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and `sat_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_vec | input | 128 | Four packed single-precision values |
| in_scale | input | 5 | Power-of-two pre-scale exponent |
| flush_dn | input | 1 | Flush denormal inputs to zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 128 | Four packed signed 32-bit results |
| out_sat | output | 1 | Some lane of this result saturated |
| sat_clear | input | 1 | Clear the sticky saturation bit |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
The hardest case to reach from the ports is a `sat_clear` pulse that lands in exactly the cycle where a saturating operand is accepted. Acceptance depends on `in_ready`, which random back-pressure can hold low. The stimulus therefore lifts back-pressure and then raises `sat_clear` together with an operand that holds an infinity, so that both events fall on one edge.

The exact -2^31 boundary and exponents near the clamp threshold are reached in two ways: with directed lanes, and with random exponents drawn from a window around 127 that straddles underflow, normal range and overflow.

// File: rtl/f2fix_pkg.sv
package f2fix_pkg;
  parameter int FP_EXP_W  = 8;
  parameter int FP_MAN_W  = 23;
  parameter int INT_W     = 32;
  parameter int SCALE_W   = 5;
  parameter int LANE_CNT  = 4;

  localparam int FP_W   = 1 + FP_EXP_W + FP_MAN_W;
  localparam int VEC_W  = FP_W * LANE_CNT;
  localparam int FP_BIAS = (1 << (FP_EXP_W - 1)) - 1;

  typedef struct packed {
    logic                sign;
    logic [FP_EXP_W-1:0] expo;
    logic [FP_MAN_W-1:0] man;
  } fp_word_t;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_FINITE = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } fp_class_t;

  typedef struct packed {
    logic [INT_W-1:0] value;
    logic             sat;
  } lane_res_t;
endpackage

// File: rtl/f2fix_classify.sv
module f2fix_classify
  import f2fix_pkg::*;
(
  input  fp_word_t            op,
  input  logic                flush_dn,
  output fp_class_t           cls,
  output logic [FP_EXP_W-1:0] eff_exp,
  output logic                hidden
);
  localparam logic [FP_EXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    cls     = CLS_FINITE;
    eff_exp = op.expo;
    hidden  = 1'b1;
    if (op.expo == EXP_ONES) begin
      cls = (op.man != '0) ? CLS_NAN : CLS_INF;
    end else if (op.expo == '0) begin
      hidden  = 1'b0;
      eff_exp = FP_EXP_W'(1);
      if (flush_dn || op.man == '0) cls = CLS_ZERO;
    end
  end
endmodule

// File: rtl/f2fix_lane.sv
module f2fix_lane
  import f2fix_pkg::*;
(
  input  fp_word_t           op,
  input  logic [SCALE_W-1:0] scale,
  input  logic               flush_dn,
  output lane_res_t          res
);
  localparam int TOP_POS = INT_W - 1;
  localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

  fp_class_t           cls;
  logic [FP_EXP_W-1:0] eff_exp;
  logic                hidden;

  f2fix_classify u_cls (
    .op      (op),
    .flush_dn(flush_dn),
    .cls     (cls),
    .eff_exp (eff_exp),
    .hidden  (hidden)
  );

  int               ue;
  logic [INT_W-1:0] sig_w;
  logic [INT_W-1:0] mag;
  logic             ovf;
  logic             exact_min;

  // Scaled exponent: plain integer add, cannot overflow to infinity.
  always_comb begin
    ue        = int'(eff_exp) - FP_BIAS + int'(scale);
    sig_w     = {{(INT_W-FP_MAN_W-1){1'b0}}, hidden, op.man};
    mag       = '0;
    ovf       = 1'b0;
    exact_min = 1'b0;
    if (ue >= TOP_POS) begin
      if (ue == TOP_POS && op.sign && hidden && op.man == '0) exact_min = 1'b1;
      else ovf = 1'b1;
    end else if (ue >= FP_MAN_W) begin
      mag = sig_w << (ue - FP_MAN_W);
    end else if (ue >= 0) begin
      mag = sig_w >> (FP_MAN_W - ue);
    end
  end

  always_comb begin
    res.value = '0;
    res.sat   = 1'b0;
    unique case (cls)
      CLS_NAN: res.sat = 1'b1;
      CLS_INF: begin
        res.value = op.sign ? INT_MIN : INT_MAX;
        res.sat   = 1'b1;
      end
      CLS_ZERO: res.value = '0;
      default: begin
        if (ovf) begin
          res.value = op.sign ? INT_MIN : INT_MAX;
          res.sat   = 1'b1;
        end else if (exact_min) begin
          res.value = INT_MIN;
        end else begin
          res.value = op.sign ? (~mag + 1'b1) : mag;
        end
      end
    endcase
  end
endmodule

// File: rtl/f2fix_sticky.sv
module f2fix_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/f2fix_scaled.sv
module f2fix_scaled
  import f2fix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_vec,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic             flush_dn,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic             out_sat,
  input  logic             sat_clear,
  output logic             sat_sticky
);
  logic [VEC_W-1:0]    lane_vec;
  logic [LANE_CNT-1:0] lane_sat;
  logic                any_sat;
  logic                accept;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    lane_res_t r;
    f2fix_lane u_lane (
      .op      (fp_word_t'(in_vec[g*FP_W +: FP_W])),
      .scale   (in_scale),
      .flush_dn(flush_dn),
      .res     (r)
    );
    assign lane_vec[g*INT_W +: INT_W] = r.value;
    assign lane_sat[g]                = r.sat;
  end

  assign any_sat  = |lane_sat;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      out_sat   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_vec   <= lane_vec;
      out_sat   <= any_sat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  f2fix_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (accept && any_sat),
    .clr_i (sat_clear),
    .flag_o(sat_sticky)
  );
endmodule

// File: rtl/f2fix_scaled_chk.sv
module f2fix_scaled_chk
  import f2fix_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic             out_sat,
  input logic             sat_clear,
  input logic             sat_sticky
);
  // R8: accepted operand shows up on the next cycle
  a_r8_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: stalled output keeps its value
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_sat));

  // R7: a saturating result leaves the sticky bit set
  a_r7_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (!out_sat || sat_sticky));

  // R7: sticky bit only drops after a clear request
  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sat_sticky) |-> $past(sat_clear));

  // R7: sticky bit only rises with a saturating result
  a_r7_rise_needs_sat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> out_valid && out_sat);
endmodule

bind f2fix_scaled f2fix_scaled_chk chk_i (.*);

// File: tb/f2fix_scaled_tb_top.sv
module f2fix_scaled_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_vec = '0;
  logic [4:0]   in_scale = '0;
  logic         flush_dn = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic         out_sat;
  logic         sat_clear = 1'b0;
  logic         sat_sticky;

  int checks = 0;
  int fails  = 0;
  bit bp     = 1'b0;
  string cur_tag = "R2";

  always #10 clk = ~clk;

  f2fix_scaled dut_i (.*);

  typedef struct { logic [127:0] vec; bit sat; string tag; } exp_t;
  exp_t q[$];
  bit   stk_exp = 1'b0;

  function automatic logic [31:0] fp(bit s, int e, int m);
    return {s, 8'(e), 23'(m)};
  endfunction

  function automatic void ref_lane(input logic [31:0] f, input int sc,
                                   output logic [31:0] r, output bit s);
    int  e;
    real v;
    e = int'(f[30:23]);
    s = 1'b0;
    r = 32'd0;
    if (e == 255) begin
      s = 1'b1;
      if (f[22:0] != 0) r = 32'd0;
      else r = f[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end else if (e != 0) begin
      v = (8388608.0 + real'(f[22:0])) * (2.0 ** real'(e - 150 + sc));
      if (f[31]) v = -v;
      if (v >= 2147483648.0) begin r = 32'h7FFF_FFFF; s = 1'b1; end
      else if (v < -2147483648.0) begin r = 32'h8000_0000; s = 1'b1; end
      else r = $rtoi(v);
    end
  endfunction

  // Behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      stk_exp = 1'b0;
    end else begin
      bit acc;
      exp_t ent;
      acc = in_valid && (q.size() == 0 || out_ready);
      if (q.size() > 0 && out_ready) void'(q.pop_front());
      if (acc) begin
        ent.sat = 1'b0;
        ent.tag = cur_tag;
        for (int i = 0; i < 4; i++) begin
          logic [31:0] r;
          bit s;
          ref_lane(in_vec[i*32 +: 32], int'(in_scale), r, s);
          ent.vec[i*32 +: 32] = r;
          ent.sat |= s;
        end
        q.push_back(ent);
      end
      if (acc && ent.sat) stk_exp = 1'b1;
      else if (sat_clear) stk_exp = 1'b0;
    end
  end

  // Compare away from the edge on every cycle
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      checks++;
      if (in_ready !== (q.size() == 0 || out_ready)) begin
        fails++;
        $display("FAIL R8 in_ready act=%0b exp=%0b", in_ready, (q.size() == 0 || out_ready));
      end
      checks++;
      if (out_valid !== (q.size() != 0)) begin
        fails++;
        $display("FAIL R8 out_valid act=%0b exp=%0b", out_valid, (q.size() != 0));
      end
      checks++;
      if (sat_sticky !== stk_exp) begin
        fails++;
        $display("FAIL R7 sat_sticky act=%0b exp=%0b", sat_sticky, stk_exp);
      end
      if (out_valid && q.size() != 0) begin
        checks++;
        if (out_vec !== q[0].vec) begin
          fails++;
          $display("FAIL %s out_vec act=%h exp=%h", q[0].tag, out_vec, q[0].vec);
        end
        checks++;
        if (out_sat !== q[0].sat) begin
          fails++;
          $display("FAIL R6 (%s) out_sat act=%0b exp=%0b", q[0].tag, out_sat, q[0].sat);
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    out_ready = bp ? 1'($urandom % 2) : 1'b1;
  end

  task automatic send(input logic [127:0] v, input int sc, input bit fd,
                      input bit clr, input string tag);
    @(negedge clk);
    #1;
    in_valid  = 1'b1;
    in_vec    = v;
    in_scale  = 5'(sc);
    flush_dn  = fd;
    sat_clear = clr;
    cur_tag   = tag;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    sat_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    #1;
    sat_clear = 1'b1;
    @(posedge clk);
    #1;
    sat_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || sat_stick_bad()) begin
      fails++;
      $display("FAIL R9 reset act=%0b%0b%0b exp=010", out_valid, in_ready, sat_sticky);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: plain values and truncation
    send({fp(0,127,0), fp(0,127,22'h200000<<1), fp(0,126,22'h200000<<1), fp(1,128,22'h200000)}, 0, 0, 0, "R2");
    send({fp(0,127,0), fp(0,127,22'h200000<<1), fp(0,126,0), fp(1,128,22'h200000)}, 1, 0, 0, "R2");
    send({fp(0,126,0), fp(1,125,0), fp(0,140,1234), fp(1,130,77)}, 15, 0, 0, "R2");
    // R1: distinct values per lane
    send({fp(0,127,0), fp(0,128,0), fp(0,129,0), fp(1,130,0)}, 3, 0, 0, "R1");
    // R7: no saturation yet, sticky still clear
    // R3: clamp boundaries and exact minimum
    send({fp(1,127,0), fp(1,127,0), fp(1,127,0), fp(1,127,0)}, 31, 0, 0, "R3");
    send({fp(0,127,0), fp(1,158,0), fp(1,158,1), fp(0,157,23'h7FFFFF)}, 0, 0, 0, "R3");
    pulse_clear();
    send({fp(0,254,5), fp(1,254,5), fp(0,200,0), fp(1,190,0)}, 31, 0, 0, "R3");
    // R4: NaN and infinities
    pulse_clear();
    send({fp(0,255,1), fp(1,255,23'h400000), fp(0,255,0), fp(1,255,0)}, 7, 0, 0, "R4");
    // R5: zeros and denormals in both modes
    send({fp(0,0,0), fp(1,0,0), fp(0,0,23'h7FFFFF), fp(1,0,1)}, 31, 0, 0, "R5");
    send({fp(0,0,0), fp(1,0,0), fp(0,0,23'h7FFFFF), fp(1,0,1)}, 31, 1, 0, "R5");
    // R6: one saturating lane among normal ones
    send({fp(0,127,0), fp(0,255,9), fp(0,128,0), fp(1,127,0)}, 0, 0, 0, "R6");
    // R7: clear alone, then clear together with a saturating operand
    pulse_clear();
    send({fp(0,255,0), fp(0,127,0), fp(0,127,0), fp(0,127,0)}, 0, 0, 1, "R7");
    repeat (2) @(negedge clk);
    send({fp(0,127,0), fp(0,127,0), fp(0,127,0), fp(0,127,0)}, 0, 0, 1, "R7");
    // R8: random traffic under back-pressure
    bp = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [127:0] v;
      for (int i = 0; i < 4; i++) begin
        int k;
        k = int'($urandom % 16);
        if (k == 0) v[i*32 +: 32] = $urandom;
        else v[i*32 +: 32] = fp(1'($urandom % 2), 100 + int'($urandom % 70), int'($urandom % 8388608));
      end
      if (n % 40 == 0) pulse_clear();
      send(v, int'($urandom % 32), 1'($urandom % 2), 1'b0, "R8");
    end
    bp = 1'b0;
    repeat (6) @(negedge clk);
    finish_run();
  end

  function automatic bit sat_stick_bad();
    return sat_sticky !== 1'b0;
  endfunction
endmodule